// File: doc/BRIEF.md
# Truncated Timestamp Seconds Extender

This block turns a compact frame timestamp into a full time value. A frame's timestamp reaches it as two 32-bit descriptor words. Together the two words carry the nanoseconds and only a short window of the low-order seconds bits. The block also receives the live 48-bit seconds count from the local time counter. From these it rebuilds the full 48-bit seconds value, under the assumption that the frame was stamped less than one field range (64 seconds) before now.

The captured low seconds bits are kept, and the live counter's upper bits are spliced above them. A wrap rule covers the case where the live counter has crossed a field boundary since the frame was stamped. In that case the top captured bit is set but the same bit of the live seconds is clear, and one full field range is taken off the result. The block registers the result and emits a single-cycle strobe one clock after each descriptor that is marked valid.

Top module: `ts_seconds_extender`

## Requirements
- R1: While reset is high and after its release, `out_vld` is 0, `out_sec` is 0 and `out_ns` is 0 until the first valid input.
- R2: `out_ns` equals bits [29:0] of `in_word_a` from the accepted input.
- R3: The truncated seconds field is 6 bits wide. Its bits [5:2] come from `in_word_b[3:0]` and its bits [1:0] come from `in_word_a[31:30]`. Unless the result is clamped, `out_sec[5:0]` equals this field.
- R4: With no wrap, `out_sec` equals `live_sec` with bits [5:0] replaced by the truncated field.
- R5: A wrap occurs when field bit 5 is 1 and `live_sec[5]` is 0. On a wrap, `out_sec` = (`live_sec` with bits [5:0] cleared) + field − 64.
- R6: If the wrap subtraction would go below zero, `out_sec` is clamped to 0.
- R7: When `in_vld` is 0, `out_vld` is 0 on the next cycle, and `out_sec` and `out_ns` keep their previous values.
- R8: Each cycle with `in_vld` high produces `out_vld` high in exactly the next cycle, carrying that input's result. Back-to-back valid inputs give back-to-back strobes.
- R9: Bits [31:4] of `in_word_b` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Descriptor timestamp valid |
| in_word_a | input | 32 | First descriptor word: nanoseconds and low seconds bits |
| in_word_b | input | 32 | Second descriptor word: high truncated seconds bits |
| live_sec | input | 48 | Current seconds from the time counter |
| out_vld | output | 1 | One-cycle result strobe |
| out_sec | output | 48 | Reconstructed seconds |
| out_ns | output | 30 | Nanoseconds |

## Verification
Every result is registered exactly once, so a wrong splice, wrap decision or field position shows at the ports on the cycle after the offending input. If the wrap rule is wrong, the result is off by exactly 64 seconds when only one of the two bit-5 values is set. If the clamp is wrong, the underflow case shows a value near the top of the 48-bit range. If the hold logic is wrong, the outputs change during a cycle that was not valid, and the next idle check catches it.

// File: rtl/ts_ext_pkg.sv
package ts_ext_pkg;

    parameter int WORD_W = 32;
    parameter int SEC_W  = 48;
    parameter int NS_W   = 30;
    parameter int LO_W   = 2;
    parameter int HI_W   = 4;

    localparam int FIELD_W = LO_W + HI_W;
    localparam int WIDE_W  = SEC_W + 2;

    typedef struct packed {
        logic [NS_W-1:0]    ns;
        logic [FIELD_W-1:0] field;
    } ts_fields_t;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } ts_full_t;

    function automatic logic field_wrapped(input logic [FIELD_W-1:0] field,
                                           input logic [SEC_W-1:0] live);
        return field[FIELD_W-1] && !live[FIELD_W-1];
    endfunction

endpackage

// File: rtl/ts_field_unpack.sv
module ts_field_unpack
    import ts_ext_pkg::*;
(
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output ts_fields_t        fields
);
    logic [LO_W-1:0] lo_part;
    logic [HI_W-1:0] hi_part;

    always_comb begin
        lo_part      = word_a[NS_W +: LO_W];
        hi_part      = word_b[HI_W-1:0];
        fields.ns    = word_a[NS_W-1:0];
        fields.field = {hi_part, lo_part};
    end
endmodule

// File: rtl/ts_sec_splice.sv
module ts_sec_splice
    import ts_ext_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic [SEC_W-1:0]   live,
    output logic [SEC_W-1:0]   sec
);
    localparam logic [WIDE_W-1:0] RANGE = WIDE_W'(1) << FIELD_W;

    logic [SEC_W-1:0]  base;
    logic [WIDE_W-1:0] sum;
    logic              wrap;

    always_comb begin
        base = {live[SEC_W-1:FIELD_W], {FIELD_W{1'b0}}};
        wrap = field_wrapped(field, live);
        sum  = {2'b00, base} + {{(WIDE_W-FIELD_W){1'b0}}, field};
        if (wrap)
            sum = sum - RANGE;
        if (sum[WIDE_W-1])
            sec = '0;
        else
            sec = sum[SEC_W-1:0];
    end
endmodule

// File: rtl/ts_seconds_extender.sv
module ts_seconds_extender
    import ts_ext_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_word_a,
    input  logic [WORD_W-1:0] in_word_b,
    input  logic [SEC_W-1:0]  live_sec,
    output logic              out_vld,
    output logic [SEC_W-1:0]  out_sec,
    output logic [NS_W-1:0]   out_ns
);
    ts_fields_t       fields;
    logic [SEC_W-1:0] spliced;
    ts_full_t         result_q;
    logic             vld_q;

    ts_field_unpack u_unpack (
        .word_a (in_word_a),
        .word_b (in_word_b),
        .fields (fields)
    );

    ts_sec_splice u_splice (
        .field (fields.field),
        .live  (live_sec),
        .sec   (spliced)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= 1'b0;
            result_q <= '0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) begin
                result_q.sec <= spliced;
                result_q.ns  <= fields.ns;
            end
        end
    end

    assign out_vld = vld_q;
    assign out_sec = result_q.sec;
    assign out_ns  = result_q.ns;
endmodule

// File: rtl/ts_seconds_extender_chk.sv
module ts_seconds_extender_chk
    import ts_ext_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [WORD_W-1:0] in_word_a,
    input logic [WORD_W-1:0] in_word_b,
    input logic [SEC_W-1:0]  live_sec,
    input logic              out_vld,
    input logic [SEC_W-1:0]  out_sec,
    input logic [NS_W-1:0]   out_ns
);
    logic nowrap;
    assign nowrap = !(in_word_b[HI_W-1] && !live_sec[FIELD_W-1]);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_vld && out_sec == '0 && out_ns == '0); // R1
    AST_NS_PASS: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_ns == $past(in_word_a[NS_W-1:0])); // R2
    AST_LOW_FIELD: assert property (@(posedge clk) disable iff (rst)
        in_vld && nowrap |=> out_sec[FIELD_W-1:0] == $past({in_word_b[HI_W-1:0], in_word_a[WORD_W-1 -: LO_W]})); // R3
    AST_UPPER_NOWRAP: assert property (@(posedge clk) disable iff (rst)
        in_vld && nowrap |=> out_sec[SEC_W-1:FIELD_W] == $past(live_sec[SEC_W-1:FIELD_W])); // R4
    AST_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_sec) && $stable(out_ns)); // R7
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld); // R8
endmodule

bind ts_seconds_extender ts_seconds_extender_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_word_a (in_word_a),
    .in_word_b (in_word_b),
    .live_sec  (live_sec),
    .out_vld   (out_vld),
    .out_sec   (out_sec),
    .out_ns    (out_ns)
);

// File: tb/sim_ts_seconds_extender.sv
module sim_ts_seconds_extender;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    localparam logic [31:0] V_A [NV] = '{32'h475BCD15, 32'hC0000000, 32'h3B9AC9FF,
                                         32'h80000005, 32'h40000001, 32'h00000010};
    localparam logic [31:0] V_B [NV] = '{32'h0000000A, 32'h0000000F, 32'hFFFFFFF2,
                                         32'h00000008, 32'h0000000F, 32'h00000001};
    localparam logic [47:0] V_LIVE [NV] = '{48'h000012345660, 48'h000000000100, 48'h800000000007,
                                            48'h000000000003, 48'hFFFFFFFFFFFF, 48'h00000000ABE0};
    localparam logic [47:0] V_SEC [NV] = '{48'h000012345669, 48'h0000000000FF, 48'h800000000008,
                                           48'h000000000000, 48'hFFFFFFFFFFFD, 48'h00000000ABC4};
    localparam logic [29:0] V_NS [NV] = '{30'h075BCD15, 30'h0, 30'h3B9AC9FF, 30'h5, 30'h1, 30'h10};

    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [31:0] in_word_a;
    logic [31:0] in_word_b;
    logic [47:0] live_sec;
    logic        out_vld;
    logic [47:0] out_sec;
    logic [29:0] out_ns;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_seconds_extender u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_word_a(in_word_a),
        .in_word_b(in_word_b), .live_sec(live_sec),
        .out_vld(out_vld), .out_sec(out_sec), .out_ns(out_ns)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] a, input logic [31:0] b, input logic [47:0] l);
        @(negedge clk);
        in_vld = v; in_word_a = a; in_word_b = b; live_sec = l;
    endtask

    initial begin
        rst = 1'b1; in_vld = 1'b0; in_word_a = '0; in_word_b = '0; live_sec = '0;
        repeat (3) @(negedge clk);
        check("R1 vld", 64'(out_vld), 64'd0);
        check("R1 sec", 64'(out_sec), 64'd0);
        check("R1 ns", 64'(out_ns), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 vld after release", 64'(out_vld), 64'd0);

        // table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, V_A[i], V_B[i], V_LIVE[i]);
            drive(1'b0, 32'h0, 32'h0, 48'h0);
            check("R8 strobe", 64'(out_vld), 64'd1);
            check("R2 R3 R4 R5 R6 R9 sec", 64'(out_sec), 64'(V_SEC[i]));
            check("R2 ns", 64'(out_ns), 64'(V_NS[i]));
            @(negedge clk);
            check("R8 single pulse", 64'(out_vld), 64'd0);
        end

        // R7: idle input with different data leaves outputs untouched
        drive(1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 48'h123456789ABC);
        drive(1'b0, 32'h12345678, 32'h0000000C, 48'h0);
        check("R7 no strobe", 64'(out_vld), 64'd0);
        check("R7 sec held", 64'(out_sec), 64'(V_SEC[NV-1]));
        check("R7 ns held", 64'(out_ns), 64'(V_NS[NV-1]));

        // R8 back-to-back
        drive(1'b1, V_A[0], V_B[0], V_LIVE[0]);
        drive(1'b1, V_A[1], V_B[1], V_LIVE[1]);
        check("R8 b2b first vld", 64'(out_vld), 64'd1);
        check("R8 b2b first sec", 64'(out_sec), 64'(V_SEC[0]));
        drive(1'b0, 32'h0, 32'h0, 48'h0);
        check("R8 b2b second vld", 64'(out_vld), 64'd1);
        check("R8 b2b second sec", 64'(out_sec), 64'(V_SEC[1]));
        check("R8 b2b second ns", 64'(out_ns), 64'(V_NS[1]));

        // R9: upper word_b bits alone differ, same result
        drive(1'b1, 32'h00000000, 32'hABCDEF05, 48'h000000001000);
        drive(1'b0, 32'h0, 32'h0, 48'h0);
        check("R9 upper bits ignored", 64'(out_sec), 64'h000000001014);

        // R1: reset mid-stream clears outputs
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears sec", 64'(out_sec), 64'd0);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule